// File: doc/BRIEF.md
# Code Protection and Encrypted Readback Unit

This block controls how the contents of an on-chip program store may be read back and reused. It keeps three protection bits and a 64-byte scrambling table. When a verify read is made, the code byte supplied by the program store is XNORed with the table byte picked by the low six bits of the read address. A table that is still erased (all ones) therefore passes code through unchanged, while a code byte of FFh reads back as the table byte itself. The same read port also answers identification reads at three fixed addresses.

The protection bits are programmed one way only, from 1 to 0, and only a whole erase restores them. Three protection levels build on each other. The lowest stops code-move reads made from external memory from fetching internal code, stops further programming and freezes the external-access strap. The middle one also blocks verify reads. The highest also blocks external execution. Patterns outside the three defined ones take the strongest defined level whose bits they include. The table is written by ANDing data into a byte, in the same way as programming, and is protected like the program store.

Top module: `prot_verify_unit`

## Requirements
- R1: After reset all three protection bits read as unprogrammed, every table byte is FFh, all permission outputs are 1, and a verify read returns the code byte unchanged.
- R2: A verify read (rd_i=1, rd_sig_i=0) presents ~(code_i ^ table[rd_addr_i[5:0]]) on rd_data_o one clock after the request, with rd_valid_o high for that cycle; a code byte of FFh therefore returns the table byte.
- R3: A table write (enc_wr_i=1) replaces the byte at enc_idx_i with its bitwise AND with enc_data_i, so bits only move from 1 to 0; the write has no effect while programming is not permitted.
- R4: Bit k of lock_pgm_i programs protection bit k (bit 0 is the first, lowest-level bit); a programmed bit stays programmed until an erase.
- R5: With the first protection bit programmed, movc_ok_o and prog_ok_o are 0.
- R6: With the first and second bits programmed, verify_en_o is 0 and every verify read returns FFh.
- R7: With all three bits programmed, exec_ok_o is 0 in addition to the R5 and R6 restrictions.
- R8: Any other pattern acts as the strongest of the above levels whose bits it contains: second and/or third bit alone act as unprotected, first and third act as the R5 level.
- R9: erase_i sets all protection bits and all table bytes to all ones, taking priority over table writes and bit programming in the same cycle.
- R10: An identification read (rd_i=1, rd_sig_i=1) returns 89h at address 30h, 58h at 31h, DEV_CODE (default FBh) at 60h and FFh elsewhere, whatever the protection level, one clock after the request.
- R11: ea_eff_o follows ea_pin_i while no protection is active; at the R5 level or above it holds the value ea_pin_i had at the first clock after reset was released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_i | input | 1 | Read request |
| rd_sig_i | input | 1 | 1 = identification read, 0 = verify read |
| rd_addr_i | input | ADDR_W | Read address |
| code_i | input | 8 | Code byte from the program store for this address |
| enc_wr_i | input | 1 | Table write strobe |
| enc_idx_i | input | 6 | Table byte index for a write |
| enc_data_i | input | 8 | Data ANDed into the table byte |
| lock_pgm_i | input | 3 | Protection bits to program this cycle |
| erase_i | input | 1 | Erase of protection bits and table |
| ea_pin_i | input | 1 | External-access strap |
| rd_data_o | output | 8 | Read result |
| rd_valid_o | output | 1 | rd_data_o holds a new result |
| verify_en_o | output | 1 | Verify reads are permitted |
| movc_ok_o | output | 1 | External code moves may fetch internal code |
| prog_ok_o | output | 1 | Further programming is permitted |
| exec_ok_o | output | 1 | External execution is permitted |
| ea_eff_o | output | 1 | Effective external-access strap |

## Verification
The hardest case to reach is a table write refused at a level that still permits verify reads, since only then can a refused write be seen at the ports; the stimulus programs the first and third bits together, which gives exactly that level, and then reads the targeted byte back. Random phases mix table writes, reads with FFh code bytes and identification addresses, strap toggles, and occasional bit programming and erases, so every protection pattern, including the undefined ones, gets visited with a non-trivial table behind it.

// File: rtl/pvu_pkg.sv
package pvu_pkg;

  localparam int unsigned LB_N   = 3;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    LVL_OPEN     = 2'd0,
    LVL_NOFETCH  = 2'd1,
    LVL_NOVERIFY = 2'd2,
    LVL_NOEXEC   = 2'd3
  } prot_lvl_e;

  // Bits are active-low: 0 means programmed. The result is the strongest
  // defined level whose programmed set is contained in the given pattern.
  function automatic prot_lvl_e lvl_from_bits(input logic [LB_N-1:0] lb_n);
    logic [LB_N-1:0] p;
    p = ~lb_n;
    if (p[0] && p[1] && p[2])  return LVL_NOEXEC;
    else if (p[0] && p[1])     return LVL_NOVERIFY;
    else if (p[0])             return LVL_NOFETCH;
    else                       return LVL_OPEN;
  endfunction

endpackage

// File: rtl/pvu_lock_ctrl.sv
module pvu_lock_ctrl
  import pvu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            erase_i,
  input  logic [LB_N-1:0] lock_pgm_i,
  input  logic            ea_pin_i,
  output logic            verify_en_o,
  output logic            movc_ok_o,
  output logic            prog_ok_o,
  output logic            exec_ok_o,
  output logic            ea_eff_o
);

  logic [LB_N-1:0] lb_q, lb_d;
  logic            lb_en;
  logic            cap_pend_q, cap_pend_d;
  logic            ea_cap_q, ea_cap_d;
  prot_lvl_e       lvl;

  // next state for protection bits
  assign lb_en = erase_i || (|lock_pgm_i);

  generate
    for (genvar k = 0; k < LB_N; k++) begin : g_bit
      always_comb begin
        if (erase_i) lb_d[k] = 1'b1;
        else         lb_d[k] = lb_q[k] & ~lock_pgm_i[k];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lb_q[k] <= 1'b1;
        else if (lb_en)  lb_q[k] <= lb_d[k];
      end
    end
  endgenerate

  // strap capture at the first clock after reset release
  always_comb begin
    cap_pend_d = 1'b0;
    ea_cap_d   = cap_pend_q ? ea_pin_i : ea_cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_pend_q <= 1'b1;
      ea_cap_q   <= 1'b0;
    end else if (cap_pend_q) begin
      cap_pend_q <= cap_pend_d;
      ea_cap_q   <= ea_cap_d;
    end
  end

  // permission decode
  always_comb begin
    lvl         = lvl_from_bits(lb_q);
    movc_ok_o   = (lvl == LVL_OPEN);
    prog_ok_o   = (lvl == LVL_OPEN);
    verify_en_o = (lvl == LVL_OPEN) || (lvl == LVL_NOFETCH);
    exec_ok_o   = (lvl != LVL_NOEXEC);
    if ((lvl != LVL_OPEN) && !cap_pend_q) ea_eff_o = ea_cap_q;
    else                                  ea_eff_o = ea_pin_i;
  end

  AST_LB_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_i |=> ((lb_q & ~$past(lb_q)) == '0)) else $error("lock bit rose without erase"); // R4

  AST_LB_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_i |=> (lb_q == '1)) else $error("erase left a lock bit programmed"); // R9

  AST_EA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl != LVL_OPEN) && !cap_pend_q) |=> ($stable(ea_eff_o) || (lvl == LVL_OPEN)))
    else $error("strap changed while frozen"); // R11

endmodule

// File: rtl/pvu_enc_store.sv
module pvu_enc_store
  import pvu_pkg::*;
#(
  parameter int unsigned BYTES = 64,
  localparam int unsigned IDX_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase_i,
  input  logic              wr_i,
  input  logic              wr_allow_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_byte_o
);

  logic [BYTE_W-1:0] mem_q [BYTES];
  logic              wr_go;

  assign wr_go = wr_i && wr_allow_i;

  generate
    for (genvar r = 0; r < BYTES; r++) begin : g_row
      logic              row_en;
      logic [BYTE_W-1:0] row_d;

      always_comb begin
        row_en = erase_i || (wr_go && (wr_idx_i == IDX_W'(r)));
        row_d  = erase_i ? '1 : (mem_q[r] & wr_data_i);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_q[r] <= '1;
        else if (row_en)  mem_q[r] <= row_d;
      end

      AST_ROW_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !wr_allow_i && !erase_i) |=> $stable(mem_q[r]))
        else $error("table row written while protected"); // R3

      AST_ROW_AND_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !erase_i |=> ((mem_q[r] & ~$past(mem_q[r])) == '0))
        else $error("table bit rose without erase"); // R3
    end
  endgenerate

  assign rd_byte_o = mem_q[rd_idx_i];

endmodule

// File: rtl/pvu_read_path.sv
module pvu_read_path
  import pvu_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [BYTE_W-1:0] DEV_CODE = 8'hFB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              sig_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] code_i,
  input  logic [BYTE_W-1:0] enc_i,
  input  logic              verify_en_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o
);

  localparam logic [ADDR_W-1:0] SIG_A0 = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] SIG_A1 = ADDR_W'(8'h31);
  localparam logic [ADDR_W-1:0] SIG_A2 = ADDR_W'(8'h60);

  logic [BYTE_W-1:0] sig_byte, ver_byte, data_d;

  always_comb begin
    if (addr_i == SIG_A0)      sig_byte = 8'h89;
    else if (addr_i == SIG_A1) sig_byte = 8'h58;
    else if (addr_i == SIG_A2) sig_byte = DEV_CODE;
    else                       sig_byte = '1;

    ver_byte = verify_en_i ? ~(code_i ^ enc_i) : '1;
    data_d   = sig_i ? sig_byte : ver_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_o <= '1;
    else if (rd_i)  data_o <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_o <= 1'b0;
    else        valid_o <= rd_i;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> valid_o) else $error("missing valid"); // R2

  AST_BLANK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !sig_i && verify_en_i && (enc_i == '1)) |=> (data_o == $past(code_i)))
    else $error("erased table altered code"); // R2

  AST_VERIFY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !sig_i && !verify_en_i) |=> (data_o == '1))
    else $error("blocked verify leaked data"); // R6

  AST_SIG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && sig_i && (addr_i == SIG_A0)) |=> (data_o == 8'h89))
    else $error("wrong identification byte"); // R10

endmodule

// File: rtl/prot_verify_unit.sv
module prot_verify_unit
  import pvu_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned ENC_BYTES = 64,
  parameter logic [7:0]  DEV_CODE  = 8'hFB,
  localparam int unsigned IDX_W    = $clog2(ENC_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              rd_sig_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [7:0]        code_i,
  input  logic              enc_wr_i,
  input  logic [IDX_W-1:0]  enc_idx_i,
  input  logic [7:0]        enc_data_i,
  input  logic [2:0]        lock_pgm_i,
  input  logic              erase_i,
  input  logic              ea_pin_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  output logic              verify_en_o,
  output logic              movc_ok_o,
  output logic              prog_ok_o,
  output logic              exec_ok_o,
  output logic              ea_eff_o
);

  logic       rst_meta_q, rst_sync_q;
  logic [7:0] enc_byte;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pvu_lock_ctrl u_lock (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .erase_i     (erase_i),
    .lock_pgm_i  (lock_pgm_i),
    .ea_pin_i    (ea_pin_i),
    .verify_en_o (verify_en_o),
    .movc_ok_o   (movc_ok_o),
    .prog_ok_o   (prog_ok_o),
    .exec_ok_o   (exec_ok_o),
    .ea_eff_o    (ea_eff_o)
  );

  pvu_enc_store #(.BYTES(ENC_BYTES)) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .erase_i    (erase_i),
    .wr_i       (enc_wr_i),
    .wr_allow_i (prog_ok_o),
    .wr_idx_i   (enc_idx_i),
    .wr_data_i  (enc_data_i),
    .rd_idx_i   (rd_addr_i[IDX_W-1:0]),
    .rd_byte_o  (enc_byte)
  );

  pvu_read_path #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_read (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .rd_i        (rd_i),
    .sig_i       (rd_sig_i),
    .addr_i      (rd_addr_i),
    .code_i      (code_i),
    .enc_i       (enc_byte),
    .verify_en_i (verify_en_o),
    .data_o      (rd_data_o),
    .valid_o     (rd_valid_o)
  );

  AST_VERIFY_BELOW_EXEC: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !exec_ok_o |-> !verify_en_o) else $error("exec blocked but verify open"); // R7

  AST_PROG_BELOW_VERIFY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !verify_en_o |-> (!prog_ok_o && !movc_ok_o)) else $error("verify blocked but programming open"); // R5

endmodule

// File: tb/sim_prot_verify_unit.sv
`timescale 1ns/1ps
module sim_prot_verify_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_i, rd_sig_i, enc_wr_i, erase_i, ea_pin_i;
  logic [15:0] rd_addr_i;
  logic [7:0]  code_i, enc_data_i;
  logic [5:0]  enc_idx_i;
  logic [2:0]  lock_pgm_i;
  logic [7:0]  rd_data_o;
  logic        rd_valid_o, verify_en_o, movc_ok_o, prog_ok_o, exec_ok_o, ea_eff_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] enc_m [64];
  logic [2:0] lb_m;
  logic       ea_cap_m;

  always #2 clk = ~clk;

  prot_verify_unit u0 (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .rd_sig_i(rd_sig_i), .rd_addr_i(rd_addr_i),
    .code_i(code_i), .enc_wr_i(enc_wr_i), .enc_idx_i(enc_idx_i), .enc_data_i(enc_data_i),
    .lock_pgm_i(lock_pgm_i), .erase_i(erase_i), .ea_pin_i(ea_pin_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .verify_en_o(verify_en_o),
    .movc_ok_o(movc_ok_o), .prog_ok_o(prog_ok_o), .exec_ok_o(exec_ok_o), .ea_eff_o(ea_eff_o)
  );

  // level from requirement R8: 0 open, 1 fetch block, 2 verify block, 3 exec block
  function automatic int exp_lvl(input logic [2:0] lb);
    if (lb == 3'b000)        return 3;
    else if (lb[1:0] == 2'b00) return 2;
    else if (!lb[0])         return 1;
    else                     return 0;
  endfunction

  function automatic logic [7:0] exp_read(input logic sig, input logic [15:0] a, input logic [7:0] c);
    if (sig) begin
      case (a)
        16'h0030: return 8'h89;
        16'h0031: return 8'h58;
        16'h0060: return 8'hFB;
        default:  return 8'hFF;
      endcase
    end
    if (exp_lvl(lb_m) >= 2) return 8'hFF;
    return ~(c ^ enc_m[a[5:0]]);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_perm(input string req);
    int l;
    logic [4:0] e;
    l = exp_lvl(lb_m);
    e = {l < 2, l == 0, l == 0, l < 3, (l >= 1) ? ea_cap_m : ea_pin_i};
    check(req, {3'b0, verify_en_o, movc_ok_o, prog_ok_o, exec_ok_o, ea_eff_o}, {3'b0, e});
  endtask

  task automatic idle_inputs();
    rd_i = 0; rd_sig_i = 0; enc_wr_i = 0; erase_i = 0; lock_pgm_i = 0;
  endtask

  task automatic t_read(input logic sig, input logic [15:0] a, input logic [7:0] c, input string req);
    logic [7:0] e;
    @(negedge clk);
    rd_i = 1; rd_sig_i = sig; rd_addr_i = a; code_i = c;
    e = exp_read(sig, a, c);
    @(posedge clk); #1;
    check(req, rd_data_o, e);
    check("R2 valid", {7'b0, rd_valid_o}, 8'h01);
    idle_inputs();
  endtask

  task automatic t_enc_wr(input logic [5:0] idx, input logic [7:0] d);
    @(negedge clk);
    enc_wr_i = 1; enc_idx_i = idx; enc_data_i = d;
    @(posedge clk); #1;
    if (exp_lvl(lb_m) == 0) enc_m[idx] = enc_m[idx] & d;
    idle_inputs();
  endtask

  task automatic t_lock(input logic [2:0] m);
    @(negedge clk);
    lock_pgm_i = m;
    @(posedge clk); #1;
    lb_m = lb_m & ~m;
    idle_inputs();
  endtask

  task automatic t_erase(input logic [5:0] idx, input logic [7:0] d, input logic [2:0] m);
    @(negedge clk);
    erase_i = 1; enc_wr_i = 1; enc_idx_i = idx; enc_data_i = d; lock_pgm_i = m;
    @(posedge clk); #1;
    lb_m = 3'b111;
    for (int i = 0; i < 64; i++) enc_m[i] = 8'hFF;
    idle_inputs();
  endtask

  task automatic t_ea(input logic v);
    @(negedge clk);
    ea_pin_i = v;
    #1;
  endtask

  task automatic random_phase(input int n, input bit with_lock);
    for (int i = 0; i < n; i++) begin
      int op;
      op = $urandom % 16;
      if (op < 6) t_enc_wr(6'($urandom), 8'($urandom) | 8'($urandom));
      else if (op < 11) t_read(1'b0, 16'($urandom), ($urandom % 4 == 0) ? 8'hFF : 8'($urandom), "R2 random verify");
      else if (op < 13) begin
        int s;
        logic [15:0] a;
        s = $urandom % 4;
        a = (s == 0) ? 16'h30 : (s == 1) ? 16'h31 : (s == 2) ? 16'h60 : 16'($urandom);
        t_read(1'b1, a, 8'($urandom), "R10 random ident");
      end
      else if (op == 13) t_ea(1'($urandom));
      else if (with_lock && op == 14) t_lock(3'(1 << ($urandom % 3)));
      else if (with_lock && op == 15 && ($urandom % 3 == 0)) t_erase(6'($urandom), 8'h00, 3'b111);
      chk_perm("R5/R6/R7/R8/R11 random");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4021));
    for (int i = 0; i < 64; i++) enc_m[i] = 8'hFF;
    lb_m = 3'b111;
    rst_n = 0; ea_pin_i = 1; rd_addr_i = 0; code_i = 0; enc_idx_i = 0; enc_data_i = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    ea_cap_m = 1'b1;
    #1;

    // R1: reset state
    chk_perm("R1 reset permissions");
    t_read(1'b0, 16'h1234, 8'h5A, "R1 erased table passes code");

    // R2 / R3 directed
    t_enc_wr(6'd5, 8'h3C);
    t_read(1'b0, 16'hA005, 8'hFF, "R2 FFh code returns table byte");
    t_read(1'b0, 16'h0045, 8'h0F, "R2 xnor with low six address bits");
    t_enc_wr(6'd5, 8'hF0);
    t_read(1'b0, 16'h0005, 8'hFF, "R3 write ANDs into byte");

    random_phase(200, 1'b0);

    // R8: second bit alone stays open
    t_lock(3'b010);
    chk_perm("R8 second bit alone");
    t_ea(1'b0);
    chk_perm("R11 strap follows when open");
    t_erase(6'd0, 8'h00, 3'b000);
    chk_perm("R9 erase restores bits");
    t_read(1'b0, 16'h0005, 8'hFF, "R9 erase restores table");

    // R8/R5: first and third -> fetch block, verify still open
    t_enc_wr(6'd9, 8'hA5);
    t_lock(3'b101);
    chk_perm("R8 first and third act as level one");
    chk_perm("R5 fetch and programming blocked");
    check("R11 strap frozen", {7'b0, ea_eff_o}, 8'h01);
    t_enc_wr(6'd9, 8'h00);
    t_read(1'b0, 16'h0009, 8'hFF, "R3 write ignored under protection");
    t_ea(1'b1);
    t_ea(1'b0);
    chk_perm("R11 strap frozen after toggle");

    // R6/R7
    t_lock(3'b010);
    chk_perm("R7 exec blocked");
    t_read(1'b0, 16'h0009, 8'h12, "R6 verify returns FFh");
    t_read(1'b1, 16'h0031, 8'h00, "R10 ident under full protection");
    t_read(1'b1, 16'h0060, 8'h00, "R10 device code");
    t_read(1'b1, 16'h0130, 8'h00, "R10 unmapped ident address");

    // R9: erase wins over write and programming in same cycle
    t_erase(6'd9, 8'h00, 3'b111);
    chk_perm("R9 erase priority over programming");
    t_read(1'b0, 16'h0009, 8'hFF, "R9 erase priority over table write");
    check("R4 mirror", {5'b0, lb_m}, 8'h07);

    // R4: bits stay programmed
    t_lock(3'b011);
    t_lock(3'b000);
    chk_perm("R4 bits stay programmed");
    t_read(1'b0, 16'h0001, 8'h77, "R6 level two verify blocked");
    t_erase(6'd0, 8'hFF, 3'b000);

    random_phase(400, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule